// File: doc/BRIEF.md
# Command Packet Front End for a Serial Display Link

This block is the write side of a display-link controller, used to send command packets to a panel. Software stages the packet body as 32-bit words in a payload queue. It then writes a 24-bit header word into a header queue. The header word holds the data type and a 16-bit field. For short packets that field carries two parameter bytes. For long packets it carries the payload byte count.

Writing the header is what launches the packet. A transmit sequencer takes headers in order and emits each packet as a byte stream with valid/ready flow control. The stream carries three header bytes, then, for long packets, exactly the counted number of payload bytes. Those bytes are taken low byte first from the payload words, and unused bytes in the last word are discarded.

Software polls a 7-bit status word before each write. Writes that hit a full queue are dropped and leave a sticky overflow flag.

Top module: `gcp_cmd_if`

## Requirements
- R1: The header word places the data type in bits [7:0] and the 16-bit header field in bits [23:8]. Each packet starts with three stream bytes: the data type, then bits [15:8], then bits [23:16].
- R2: A packet whose data type has low nibble other than 4'h9 is short. It is exactly three bytes long, with `tx_last` asserted on the third byte only.
- R3: A packet whose data type has low nibble 4'h9 is long, and its header field is a byte count N. After the header it emits exactly N payload bytes. Byte k is byte (k mod 4) of payload word k/4, where byte 0 is bits [7:0]. The packet consumes exactly ceil(N/4) payload words, and `tx_last` marks the final byte; when N is 0 it marks the third header byte.
- R4: Status bit 0 is header queue empty, bit 1 header queue full, bit 2 payload queue empty, bit 3 payload queue full. Bit 4 (read data empty) is always 1. Bits 5 (read data full) and 6 (read busy) are always 0.
- R5: A header write while the header queue is full is discarded and sets `hdr_ovf`, which stays set until reset. The queued headers are unchanged.
- R6: A payload write while the payload queue is full is discarded and sets `pld_ovf`, which stays set until reset. The queued words are unchanged.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R8: After reset the status reads 7'h15, both overflow flags are 0 and `tx_valid` is 0.
- R9: Packets leave in header write order, and payload words are consumed in write order across packets.
- R10: If a long packet needs a payload word and the payload queue is empty, `tx_valid` stays low until a word is written. Transmission then resumes with that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_we | input | 1 | Header write strobe |
| hdr_wdata | input | 24 | Header word: {field[15:0], data type[7:0]} |
| pld_we | input | 1 | Payload write strobe |
| pld_wdata | input | 32 | Payload word, first byte in bits [7:0] |
| status | output | 7 | Queue status word (see R4) |
| hdr_ovf | output | 1 | Sticky header drop flag |
| pld_ovf | output | 1 | Sticky payload drop flag |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a packet |

## Verification
A corrupt queue pointer or count shows up at the ports as bytes out of order, or as a wrong empty/full bit, on the cycle after the faulty push or pop. A wrong remaining-byte count or byte index in the sequencer shows within one packet. It appears as a misplaced `tx_last`, a stray byte after the packet, or leftover or missing payload words, which the payload-empty bit reveals once the packet has drained. Backpressure on some packets exposes any state that moves without a handshake.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DT,
    ST_LO,
    ST_HI,
    ST_PLD
  } seq_st_e;

  // long packets carry a byte count; identified by low nibble 9
  function automatic logic is_long_dt(input logic [7:0] dt);
    return dt[3:0] == 4'h9;
  endfunction

  // little-endian byte lane selection from a payload word
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] idx);
    return w[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/gcp_fifo.sv
module gcp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign head_o  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R9
  AST_FIFO_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> full_o); // R5
endmodule

// File: rtl/gcp_tx.sv
module gcp_tx
  import gcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] cmd_head,
  input  logic        cmd_empty,
  input  logic [31:0] pld_head,
  input  logic        pld_empty,
  output logic        cmd_pop,
  output logic        pld_pop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);
  seq_st_e     st;
  logic [23:0] hdr_q;
  logic [15:0] rem;
  logic [1:0]  bidx;
  logic        long_q, fire, hdr_end;

  assign long_q  = is_long_dt(hdr_q[7:0]);
  assign hdr_end = !long_q || (hdr_q[23:8] == 16'd0);
  assign fire    = out_valid && out_ready;
  assign cmd_pop = (st == ST_IDLE) && !cmd_empty;
  assign pld_pop = (st == ST_PLD) && fire && ((bidx == 2'd3) || (rem == 16'd1));

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    case (st)
      ST_DT:  begin out_valid = 1'b1; out_data = hdr_q[7:0]; end
      ST_LO:  begin out_valid = 1'b1; out_data = hdr_q[15:8]; end
      ST_HI:  begin out_valid = 1'b1; out_data = hdr_q[23:16]; out_last = hdr_end; end
      ST_PLD: begin
        out_valid = !pld_empty;
        out_data  = pick_byte(pld_head, bidx);
        out_last  = (rem == 16'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      hdr_q <= '0;
      rem   <= '0;
      bidx  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (!cmd_empty) begin
          hdr_q <= cmd_head;
          st    <= ST_DT;
        end
        ST_DT: if (fire) st <= ST_LO;
        ST_LO: if (fire) st <= ST_HI;
        ST_HI: if (fire) begin
          rem  <= hdr_q[23:8];
          bidx <= 2'd0;
          st   <= hdr_end ? ST_IDLE : ST_PLD;
        end
        ST_PLD: if (fire) begin
          rem  <= rem - 1'b1;
          bidx <= bidx + 1'b1;
          if (rem == 16'd1) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
  AST_LAST_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> !out_valid); // R2
  AST_PLD_POP_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pld_pop |-> (long_q && !pld_empty)); // R3
endmodule

// File: rtl/gcp_cmd_if.sv
module gcp_cmd_if #(
  parameter int CMD_DEPTH = 4,
  parameter int PLD_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_we,
  input  logic [23:0] hdr_wdata,
  input  logic        pld_we,
  input  logic [31:0] pld_wdata,
  output logic [6:0]  status,
  output logic        hdr_ovf,
  output logic        pld_ovf,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last
);
  localparam int ST_CMD_EMPTY = 0;
  localparam int ST_CMD_FULL  = 1;
  localparam int ST_PLD_EMPTY = 2;
  localparam int ST_PLD_FULL  = 3;
  localparam int ST_RD_EMPTY  = 4;
  localparam int ST_RD_FULL   = 5;
  localparam int ST_RD_BUSY   = 6;

  logic [23:0] cmd_head;
  logic [31:0] pld_head;
  logic cmd_empty, cmd_full, cmd_drop, cmd_pop;
  logic pld_empty, pld_full, pld_drop, pld_pop;

  gcp_fifo #(.W(24), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .push_i(hdr_we), .data_i(hdr_wdata), .pop_i(cmd_pop),
    .head_o(cmd_head), .empty_o(cmd_empty), .full_o(cmd_full), .drop_o(cmd_drop));

  gcp_fifo #(.W(32), .DEPTH(PLD_DEPTH)) u_pld_q (
    .clk(clk), .rst_n(rst_n), .push_i(pld_we), .data_i(pld_wdata), .pop_i(pld_pop),
    .head_o(pld_head), .empty_o(pld_empty), .full_o(pld_full), .drop_o(pld_drop));

  gcp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cmd_head(cmd_head), .cmd_empty(cmd_empty),
    .pld_head(pld_head), .pld_empty(pld_empty), .cmd_pop(cmd_pop), .pld_pop(pld_pop),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data), .out_last(tx_last));

  always_comb begin
    status               = '0;
    status[ST_CMD_EMPTY] = cmd_empty;
    status[ST_CMD_FULL]  = cmd_full;
    status[ST_PLD_EMPTY] = pld_empty;
    status[ST_PLD_FULL]  = pld_full;
    status[ST_RD_EMPTY]  = 1'b1;
    status[ST_RD_FULL]   = 1'b0;
    status[ST_RD_BUSY]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_ovf <= 1'b0;
      pld_ovf <= 1'b0;
    end else begin
      if (cmd_drop) hdr_ovf <= 1'b1;
      if (pld_drop) pld_ovf <= 1'b1;
    end
  end

  AST_HDR_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ovf |=> hdr_ovf); // R5
  AST_PLD_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pld_ovf |=> pld_ovf); // R6
  AST_HDR_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_we && status[ST_CMD_FULL]) |=> hdr_ovf); // R5
  AST_PLD_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_we && status[ST_PLD_FULL]) |=> pld_ovf); // R6
  AST_CMD_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_CMD_EMPTY] && status[ST_CMD_FULL])); // R4
endmodule

// File: tb/gcp_cmd_if_tb_top.sv
module gcp_cmd_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_we = 1'b0;
  logic [23:0] hdr_wdata = '0;
  logic pld_we = 1'b0;
  logic [31:0] pld_wdata = '0;
  logic [6:0] status;
  logic hdr_ovf, pld_ovf, tx_valid, tx_last;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  gcp_cmd_if dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_we(hdr_we), .hdr_wdata(hdr_wdata),
    .pld_we(pld_we), .pld_wdata(pld_wdata), .status(status), .hdr_ovf(hdr_ovf),
    .pld_ovf(pld_ovf), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last));

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit bp = 0;
  int wseq = 0;
  logic [7:0]  got [64];
  logic        got_last [64];
  logic [31:0] words [16];
  int nwords = 0;

  // {field16, data type}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    24'h0011_05, 24'hB051_15, 24'h0003_39, 24'h0004_29,
    24'h000B_39, 24'h0000_29, 24'h0020_29 };

  function automatic logic [31:0] pw(input int n);
    return 32'h1122_3344 ^ (32'(n) * 32'h9E37_79B1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_hdr(input logic [23:0] h);
    @(negedge clk); hdr_we = 1'b1; hdr_wdata = h;
    @(negedge clk); hdr_we = 1'b0;
  endtask

  task automatic wr_pld(input logic [31:0] w);
    @(negedge clk); pld_we = 1'b1; pld_wdata = w;
    @(negedge clk); pld_we = 1'b0;
  endtask

  task automatic stage_word();
    words[nwords] = pw(wseq);
    wr_pld(pw(wseq));
    nwords++;
    wseq++;
  endtask

  task automatic get_bytes(input int n);
    int k = 0;
    int tick = 0;
    while (k < n && tick < 2000) begin
      @(negedge clk);
      tx_ready = bp ? tick[0] : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        got[k] = tx_data;
        got_last[k] = tx_last;
        k++;
      end
      tick++;
    end
    @(negedge clk);
    tx_ready = 1'b0;
    if (k < n) chk(1'b0, "R9 stream timeout", 32'(k), 32'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 7'h15, "R8 R4 reset status", 32'(status), 32'h15);
    chk(!hdr_ovf && !pld_ovf, "R8 reset flags", {hdr_ovf, pld_ovf}, 0);
    chk(!tx_valid, "R8 reset valid", 32'(tx_valid), 0);

    // table-driven packets: R1 R2 R3 R9
    for (int i = 0; i < NV; i++) begin
      logic [23:0] h;
      int n;
      bit lng;
      h = VEC[i];
      lng = (h[3:0] == 4'h9);
      n = lng ? int'(h[23:8]) : 0;
      nwords = 0;
      for (int w = 0; w < (n + 3) / 4; w++) stage_word();
      bp = i[0];
      wr_hdr(h);
      get_bytes(3 + n);
      chk(got[0] == h[7:0], "R1 type byte", 32'(got[0]), 32'(h[7:0]));
      chk(got[1] == h[15:8] && got[2] == h[23:16], "R1 field bytes",
          {got[1], got[2]}, {h[15:8], h[23:16]});
      for (int k = 0; k < n; k++)
        chk(got[3+k] == words[k/4][(k%4)*8 +: 8], "R3 payload byte",
            32'(got[3+k]), 32'(words[k/4][(k%4)*8 +: 8]));
      for (int k = 0; k < 3 + n; k++)
        chk(got_last[k] == (k == 2 + n), lng ? "R3 last marker" : "R2 last marker",
            32'(got_last[k]), 32'(k == 2 + n));
      repeat (3) @(negedge clk);
      chk(!tx_valid, "R2 R3 no extra byte", 32'(tx_valid), 0);
      chk(status[2] == 1'b1, "R3 words consumed", 32'(status), 32'h4);
    end
    bp = 0;

    // R7: stall holds output
    wr_hdr(24'h7A5C_15);
    repeat (4) @(negedge clk);
    chk(tx_valid && tx_data == 8'h15, "R7 stall hold", {tx_valid, tx_data}, 32'h115);
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_data == 8'h15 && !tx_last, "R7 stall stable", {tx_valid, tx_data}, 32'h115);
    get_bytes(3);
    chk(got[1] == 8'h5C && got[2] == 8'h7A && got_last[2], "R7 after stall",
        {got[1], got[2]}, 32'h5C7A);

    // R10: payload starvation
    nwords = 0;
    stage_word();
    wr_hdr(24'h0008_29);
    get_bytes(7);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R10 wait for word", 32'(tx_valid), 0);
    stage_word();
    get_bytes(4);
    for (int k = 0; k < 4; k++)
      chk(got[k] == words[1][k*8 +: 8] && got_last[k] == (k == 3), "R10 resume byte",
          32'(got[k]), 32'(words[1][k*8 +: 8]));

    // R5: header queue overflow
    wr_hdr(24'h0001_05);
    repeat (3) @(negedge clk);
    for (int k = 2; k <= 5; k++) wr_hdr({16'(k), 8'h05});
    chk(status[1] && !status[0], "R4 cmd full bit", 32'(status), 32'h2);
    chk(!hdr_ovf, "R5 no flag before drop", 32'(hdr_ovf), 0);
    wr_hdr(24'h0006_05);
    chk(hdr_ovf, "R5 drop flag", 32'(hdr_ovf), 1);
    get_bytes(15);
    for (int k = 0; k < 5; k++)
      chk(got[3*k] == 8'h05 && got[3*k+1] == 8'(k + 1), "R5 R9 queued order",
          32'(got[3*k+1]), 32'(k + 1));
    repeat (3) @(negedge clk);
    chk(!tx_valid && status[0], "R5 dropped header absent", {tx_valid, status[0]}, 32'h1);
    chk(hdr_ovf, "R5 flag sticky", 32'(hdr_ovf), 1);

    // R6: payload queue overflow
    nwords = 0;
    for (int k = 0; k < 8; k++) stage_word();
    chk(status[3] && !status[2], "R4 pld full bit", 32'(status), 32'h8);
    chk(!pld_ovf, "R6 no flag before drop", 32'(pld_ovf), 0);
    wr_pld(32'hDEAD_BEEF);
    chk(pld_ovf, "R6 drop flag", 32'(pld_ovf), 1);
    wr_hdr(24'h0020_39);
    get_bytes(35);
    for (int k = 0; k < 32; k++)
      chk(got[3+k] == words[k/4][(k%4)*8 +: 8], "R6 queued words kept",
          32'(got[3+k]), 32'(words[k/4][(k%4)*8 +: 8]));
    repeat (3) @(negedge clk);
    chk(status[2] && !tx_valid, "R6 dropped word absent", 32'(status), 32'h15);
    chk(status[6:4] == 3'b001, "R4 read bits", 32'(status[6:4]), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule